// File: doc/BRIEF.md
# Synchronous Serial Port with Collision Flag

This block is an 8-bit synchronous serial port that hangs off a microcontroller's register bus. A single register serves as both the outgoing byte and the incoming byte. In master mode, writing that register starts a transfer. The block then generates its own serial clock by dividing the bus clock. It shifts the byte out most significant bit first and shifts the reply in on the same clock.

A status register carries two flags. The first is a transfer-complete flag. The second is a collision flag, raised when software touches the data register while a transfer is running. Both flags clear through a two-step sequence: read the status register, then read or write the data register. The first step is remembered in an internal armed bit, and any later data access completes the sequence. If the clearing step lands inside a transfer, the completion flag returns at that transfer's end and the collision flag is raised again.

The register bus offers one address bit, a select, single-cycle read and write strobes, write data, and combinational read data.

Top module: `sio_port`

## Requirements
- R1: After reset both status flags read 0, the serial clock output is high and the serial data output is high.
- R2: A data-register write (address bit 0) while idle starts an 8-bit transfer. The serial clock stays high while idle and spends CLK_DIV bus cycles in each half period. Serial data out changes only on falling serial-clock edges, most significant bit first.
- R3: On each rising serial-clock edge the port samples serial data in. After the transfer the data register holds the received byte, with the first sampled bit in bit 7.
- R4: The transfer-complete flag (status bit 7) sets on the eighth rising serial-clock edge, 16*CLK_DIV bus cycles after the starting write. It reads 0 one cycle earlier.
- R5: The transfer-complete flag clears only when a status read (address bit 1) taken while it is set is followed by a data-register read or write. A data access alone, or a status read alone, leaves it set.
- R6: Any data-register read or write after the first falling serial-clock edge and before the transfer ends sets the collision flag (status bit 6). An access before the first falling edge does not.
- R7: The collision flag clears when a status read taken with the transfer-complete flag set is followed by a data access outside the collision window.
- R8: If the transfer-complete flag is cleared while a transfer is running, it sets again at the end of that transfer.
- R9: When the clearing data access falls inside a new transfer's collision window, the transfer-complete flag clears but the collision flag is set.
- R10: The data register is single buffered. A write during a transfer overwrites it, and a write before the first falling edge changes the byte that is sent.
- R11: Reset leaves the data register contents unchanged.
- R12: Read data always shows the addressed register. Status bits 5..0 read 0, and writes to the status address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Port select |
| addr_i | input | 1 | 0 = data register, 1 = status register |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The following are checked by assertions on every cycle:
- the serial clock stays high while idle;
- serial data out moves only on a falling serial-clock edge;
- the completion flag rises only together with a rising serial-clock edge;
- either flag falls only after an armed data access;
- the collision flag rises only after a data access during a transfer.

Only the bench's scenarios can show the following:
- the transmitted and received byte values;
- the exact completion cycle;
- the overwrite of the byte before the first falling edge;
- the re-arming after an early clear;
- that the data register survives reset.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    SIO_DATA = 1'b0,
    SIO_STAT = 1'b1
  } sio_addr_e;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o,
  output logic last_o,
  output logic win_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          busy_q, sck_q, fell_q;
  logic          tick;

  assign tick   = busy_q && (cnt_q == CW'(CLK_DIV - 1));
  assign fall_o = tick && sck_q;
  assign rise_o = tick && !sck_q;
  assign last_o = rise_o && (bit_q == BW'(DATA_W - 1));
  assign win_o  = busy_q && fell_q;
  assign busy_o = busy_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b1;
      fell_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        bit_q  <= '0;
        fell_q <= 1'b0;
      end
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) sck_q <= ~sck_q;
      if (fall_o) fell_q <= 1'b1;
      if (rise_o) bit_q <= bit_q + 1'b1;
      if (last_o) begin
        busy_q <= 1'b0;
        fell_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] sr_o,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sr_q;
  logic              sdo_q;

  // data register has no reset by intent
  always_ff @(posedge clk_i) begin
    if (wr_i)        sr_q <= wdata_i;
    else if (rise_i) sr_q <= {sr_q[DATA_W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sdo_q <= 1'b1;
    else if (fall_i) sdo_q <= sr_q[DATA_W-1];
  end

  assign sr_o  = sr_q;
  assign sdo_o = sdo_q;
endmodule

// File: rtl/sio_flags.sv
module sio_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic win_i,
  input  logic done_i,
  output logic spif_o,
  output logic dcol_o,
  output logic armed_o
);
  logic spif_q, dcol_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spif_q  <= 1'b0;
      dcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (data_acc_i)     armed_q <= 1'b0;
      else if (stat_rd_i) armed_q <= spif_q;

      if (done_i)                     spif_q <= 1'b1;
      else if (data_acc_i && armed_q) spif_q <= 1'b0;

      if (data_acc_i && win_i)        dcol_q <= 1'b1;
      else if (data_acc_i && armed_q) dcol_q <= 1'b0;
    end
  end

  assign spif_o  = spif_q;
  assign dcol_o  = dcol_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  import sio_pkg::*;

  logic data_sel, data_acc, data_wr, stat_rd, start;
  logic busy, fall, rise, last, win;
  logic spif, dcol, armed;
  logic [DATA_W-1:0] sr, stat_word;

  assign data_sel = sel_i && (sio_addr_e'(addr_i) == SIO_DATA);
  assign data_acc = data_sel && (rd_i || wr_i);
  assign data_wr  = data_sel && wr_i;
  assign stat_rd  = sel_i && (sio_addr_e'(addr_i) == SIO_STAT) && rd_i;
  assign start    = data_wr && !busy;

  sio_clkgen #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .sck_o  (sck_o),
    .fall_o (fall),
    .rise_o (rise),
    .last_o (last),
    .win_o  (win)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (data_wr),
    .wdata_i(wdata_i),
    .fall_i (fall),
    .rise_i (rise),
    .sdi_i  (sdi_i),
    .sr_o   (sr),
    .sdo_o  (sdo_o)
  );

  sio_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_rd_i (stat_rd),
    .data_acc_i(data_acc),
    .win_i     (win),
    .done_i    (last),
    .spif_o    (spif),
    .dcol_o    (dcol),
    .armed_o   (armed)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[DATA_W-1] = spif;
    stat_word[DATA_W-2] = dcol;
  end

  assign rdata_o = (sio_addr_e'(addr_i) == SIO_STAT) ? stat_word : sr;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic sdo_o,
  input logic spif,
  input logic dcol,
  input logic armed,
  input logic busy,
  input logic data_acc
);
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o); // R2
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $fell(sck_o)); // R2
  AST_SPIF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spif) |-> $rose(sck_o)); // R4
  AST_SPIF_CLEAR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spif) |-> $past(armed && data_acc)); // R5
  AST_DCOL_SET_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dcol) |-> $past(data_acc && busy)); // R6
  AST_DCOL_CLEAR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dcol) |-> $past(armed && data_acc)); // R7
endmodule

bind sio_port sio_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sck_o   (sck_o),
  .sdo_o   (sdo_o),
  .spif    (spif),
  .dcol    (dcol),
  .armed   (armed),
  .busy    (busy),
  .data_acc(data_acc)
);

// File: tb/sio_port_tb.sv
`timescale 1ns/1ps
module sio_port_tb;
  localparam int DIV = 4;
  localparam int XFER = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, addr = 0, rd = 0, wr = 0, sdi;
  logic [7:0] wdata = 0, rdata;
  logic sck, sdo;

  logic [7:0] sl_byte = 8'h00, mosi = 8'h00;
  int sidx = 0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sio_port #(.CLK_DIV(DIV), .DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .sdo_o(sdo),
    .sdi_i(sdi)
  );

  // remote slave model
  assign sdi = (sidx < 8) ? sl_byte[7 - sidx] : 1'b0;
  always @(posedge sck) begin
    mosi = {mosi[6:0], sdo};
    sidx = sidx + 1;
  end

  function automatic logic [7:0] stat_exp(input logic f, input logic c);
    return {f, c, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic a, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = 1; addr = a; rd = !w; wr = w; wdata = d;
    @(negedge clk);
    sel = 0; rd = 0; wr = 0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic arm_slave(input logic [7:0] b);
    sl_byte = b; sidx = 0; mosi = 8'h00;
  endtask

  // clear flags, run a full transfer, check result and timing
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input string tag);
    logic [7:0] v;
    acc(1, 0, 0);
    arm_slave(rx);
    acc(0, 1, tx);
    repeat (XFER - 1) @(negedge clk);
    peek(1, v); chk({tag, " R4 before end"}, v & 8'h80, 8'h00);
    @(negedge clk);
    peek(1, v); chk({tag, " R4 at end"}, v & 8'h80, 8'h80);
    chk({tag, " R2 sent"}, mosi, tx);
    peek(0, v); chk({tag, " R3 received"}, v, rx);
  endtask

  initial begin
    #(100000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, last_rx;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(1, v); chk("R1 flags", v, stat_exp(0, 0));
    chk("R1 sck", {7'b0, sck}, 8'h01);
    chk("R1 sdo", {7'b0, sdo}, 8'h01);

    xfer(8'hA5, 8'h3C, "dir1");

    // R5: each step alone does not clear
    acc(0, 0, 0); peek(1, v); chk("R5 data access alone", v, stat_exp(1, 0));
    acc(1, 1, 8'hFF); peek(1, v); chk("R12 status write ignored", v, stat_exp(1, 0));
    peek(0, v); chk("R12 data unchanged by status write", v, 8'h3C);
    acc(1, 0, 0); peek(1, v); chk("R5 status read alone", v, stat_exp(1, 0));
    acc(0, 0, 0); peek(1, v); chk("R5 sequence clears", v, stat_exp(0, 0));

    // R10: overwrite before first falling edge, no collision
    arm_slave(8'h96);
    acc(0, 1, 8'hB1);
    acc(0, 1, 8'h4E);
    peek(1, v); chk("R6 early access no collision", v, stat_exp(0, 0));
    repeat (XFER) @(negedge clk);
    chk("R10 overwritten byte sent", mosi, 8'h4E);
    peek(1, v); chk("R6 flags after early overwrite", v, stat_exp(1, 0));

    // R6/R7: collision inside window then clear
    acc(1, 0, 0);
    arm_slave(8'h0F);
    acc(0, 1, 8'h11);
    repeat (DIV + 2) @(negedge clk);
    acc(0, 0, 0); peek(1, v); chk("R6 collision set", v, stat_exp(0, 1));
    repeat (XFER) @(negedge clk);
    peek(1, v); chk("R6 flags at end", v, stat_exp(1, 1));
    acc(1, 0, 0); acc(0, 0, 0); peek(1, v); chk("R7 collision cleared", v, stat_exp(0, 0));

    // R8: clear while new transfer runs, flag returns
    xfer(8'h5A, 8'hC3, "dir2");
    acc(1, 0, 0);
    arm_slave(8'h77);
    acc(0, 1, 8'h88);
    peek(1, v); chk("R8 cleared mid transfer", v, stat_exp(0, 0));
    repeat (XFER) @(negedge clk);
    peek(1, v); chk("R8 set again at end", v, stat_exp(1, 0));

    // R9: armed access inside window of another transfer
    arm_slave(8'h21);
    acc(0, 1, 8'h12);
    peek(1, v); chk("R5 start write leaves flag", v, stat_exp(1, 0));
    repeat (DIV + 2) @(negedge clk);
    acc(1, 0, 0);
    acc(0, 0, 0); peek(1, v); chk("R9 spif clear dcol set", v, stat_exp(0, 1));
    repeat (XFER) @(negedge clk);
    peek(1, v); chk("R9 spif back at end", v, stat_exp(1, 1));
    peek(0, last_rx);

    // R11: reset keeps data register
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    peek(0, v); chk("R11 data survives reset", v, last_rx);
    peek(1, v); chk("R1 flags after reset", v, stat_exp(0, 0));

    for (int i = 0; i < 20; i++) begin
      logic [7:0] t, r;
      t = 8'($urandom); r = 8'($urandom);
      xfer(t, r, "rnd");
      peek(1, v); chk("R12 status low bits", v & 8'h3F, 8'h00);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule